// File: doc/BRIEF.md
# Fixed-Peripheral DMA Channel

This block is one DMA channel. Each request it accepts makes it move a single byte or a single word between a memory location and a peripheral location. One endpoint is a 24-bit memory pointer. It moves up or down after every transfer. The other endpoint is a peripheral location that never moves. Its low 8 bits come from a short register and every bit above them reads as one. The channel keeps working until its 16-bit transfer counter runs out. It then switches itself off and raises a one-clock end interrupt.

The channel has no direction bit. The source that raised the request sets the direction. A request from the serial receive-full source copies peripheral data into memory. A request from any other source copies memory data out to the peripheral. Each transfer is one read bus cycle from the source followed by one write bus cycle to the destination. Each bus cycle holds until the bus signals ready.

Software sets up the channel through four write ports: the memory pointer, the peripheral low byte, the count and control. The control word has bit 0 for enable, bit 1 for word size and bit 2 for downward stepping.

Top module: `dma_io_channel`

## Requirements
- R1: Each accepted request produces exactly one read bus cycle (`bus_we_o`=0) at the source address. The next cycle is exactly one write bus cycle (`bus_we_o`=1) at the destination address. The write carries the data that the read returned.
- R2: When `req_src_i` equals `RX_SRC` (default 2), the read goes to the peripheral address and the write goes to the memory address.
- R3: For any other `req_src_i` value, the read goes to the memory address and the write goes to the peripheral address.
- R4: The peripheral address is `{16'hFFFF, io_low}`. No transfer ever changes `io_low`.
- R5: After each transfer, the memory pointer moves by 1 in byte mode or by 2 in word mode. It moves up when control bit 2 is 0 and down when control bit 2 is 1.
- R6: The count drops by one per transfer. When a transfer brings it to zero, control bit 0 clears and `end_irq_o` is high for exactly one clock.
- R7: A request is ignored in any of these cases: the channel is disabled, a transfer is in progress, or the count is zero. An ignored request leaves no bus cycle and no register change.
- R8: In word mode, bit 0 of every bus address is driven to zero. In byte mode, only `bus_rdata_i[7:0]` is kept, and the write data has its upper byte zero.
- R9: While `bus_req_o` is high and `bus_rdy_i` is low, the address and the direction of the bus cycle hold steady into the next clock.
- R10: During reset, `bus_req_o`, `end_irq_o` and the enable bit are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mar_we_i | input | 1 | Write strobe for the memory pointer |
| mar_wd_i | input | 24 | Memory pointer write value |
| io_we_i | input | 1 | Write strobe for the peripheral low byte |
| io_wd_i | input | 8 | Peripheral low byte write value |
| cnt_we_i | input | 1 | Write strobe for the transfer count |
| cnt_wd_i | input | 16 | Transfer count write value |
| ctl_we_i | input | 1 | Write strobe for control |
| ctl_wd_i | input | 3 | Control: bit0 enable, bit1 word, bit2 step down |
| req_i | input | 1 | Transfer request |
| req_src_i | input | 3 | Identifier of the requesting source |
| bus_req_o | output | 1 | Bus cycle active |
| bus_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_o | output | 24 | Bus address |
| bus_word_o | output | 1 | 1 = word access, 0 = byte access |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| bus_rdy_i | input | 1 | Bus cycle completes at this clock |
| mar_o | output | 24 | Current memory pointer |
| cnt_o | output | 16 | Current transfer count |
| en_o | output | 1 | Current enable bit |
| end_irq_o | output | 1 | End-of-transfer pulse |

## Verification
Assertions check the following on every clock:
- A bus cycle holds while ready is low.
- A completed read is always followed by a write.
- Word addresses stay even.
- The end pulse lasts one clock and comes with the enable bit clear.
- A disabled idle channel stays off the bus.

Some behaviour only the bench scenarios can show. These scenarios use a scoreboard that predicts every bus cycle. They cover:
- the direction chosen by each source;
- the fixed all-ones upper peripheral address;
- the exact pointer steps for byte, word, up and down;
- the count reaching zero;
- requests dropped while disabled, busy or at zero count.

// File: rtl/dma_io_pkg.sv
package dma_io_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  // bit 0 enable, bit 1 word size, bit 2 step down
  typedef struct packed {
    logic dec;
    logic word;
    logic en;
  } ctl_t;

endpackage

// File: rtl/dma_io_regs.sv
module dma_io_regs
  import dma_io_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_we_i,
  input  logic [ADDR_W-1:0] mar_wd_i,
  input  logic              io_we_i,
  input  logic [IO_W-1:0]   io_wd_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wd_i,
  input  logic              ctl_we_i,
  input  ctl_t              ctl_wd_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] mar_next_i,
  output logic [ADDR_W-1:0] mar_q_o,
  output logic [IO_W-1:0]   io_q_o,
  output logic [CNT_W-1:0]  cnt_q_o,
  output ctl_t              ctl_q_o,
  output logic              last_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] mar_d, mar_q;
  logic [IO_W-1:0]   io_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  ctl_t              ctl_d, ctl_q;
  logic              mar_ce, cnt_ce, ctl_ce, last;

  assign last = (cnt_q == CNT_ONE);

  // Transfer updates take priority over software writes in the same cycle.
  always_comb begin
    mar_d  = mar_wd_i;
    mar_ce = mar_we_i | step_i;
    if (step_i) mar_d = mar_next_i;

    cnt_d  = cnt_wd_i;
    cnt_ce = cnt_we_i | step_i;
    if (step_i) cnt_d = cnt_q - CNT_ONE;

    ctl_d  = ctl_we_i ? ctl_wd_i : ctl_q;
    ctl_ce = ctl_we_i | (step_i & last);
    if (step_i && last) ctl_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      io_q  <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (mar_ce)   mar_q <= mar_d;
      if (io_we_i)  io_q  <= io_wd_i;
      if (cnt_ce)   cnt_q <= cnt_d;
      if (ctl_ce)   ctl_q <= ctl_d;
    end
  end

  assign mar_q_o = mar_q;
  assign io_q_o  = io_q;
  assign cnt_q_o = cnt_q;
  assign ctl_q_o = ctl_q;
  assign last_o  = last;

endmodule

// File: rtl/dma_io_addr.sv
module dma_io_addr #(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8
) (
  input  logic [ADDR_W-1:0] mar_i,
  input  logic [IO_W-1:0]   io_i,
  input  logic              word_i,
  input  logic              dec_i,
  input  logic              from_io_i,
  output logic [ADDR_W-1:0] mar_next_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);

  localparam int PAD_W = ADDR_W - IO_W;

  logic [ADDR_W-1:0] step, io_full, mem_a, io_a;

  generate
    if (PAD_W > 0) begin : g_pad
      assign io_full = {{PAD_W{1'b1}}, io_i};
    end else begin : g_nopad
      assign io_full = io_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    step       = word_i ? ADDR_W'(2) : ADDR_W'(1);
    mar_next_o = dec_i ? (mar_i - step) : (mar_i + step);
    mem_a      = mar_i;
    io_a       = io_full;
    if (word_i) begin
      mem_a[0] = 1'b0;
      io_a[0]  = 1'b0;
    end
    src_o = from_io_i ? io_a  : mem_a;
    dst_o = from_io_i ? mem_a : io_a;
  end

endmodule

// File: rtl/dma_io_seq.sv
module dma_io_seq
  import dma_io_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 3,
  parameter int RX_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              word_i,
  input  logic              cnt_nz_i,
  input  logic              last_i,
  input  logic              req_i,
  input  logic [SRC_W-1:0]  src_id_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdy_i,
  output logic              from_io_o,
  output logic              step_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              irq_o
);

  localparam logic [SRC_W-1:0] RX_ID = SRC_W'(RX_SRC);
  localparam int HI_W = DATA_W - 8;

  seq_state_e        state_d, state_q;
  logic              dir_d, dir_q, dir_ce;
  logic [DATA_W-1:0] data_d, data_q;
  logic              data_ce, irq_d, irq_q, accept, step;

  always_comb begin
    accept  = (state_q == ST_IDLE) & en_i & cnt_nz_i & req_i;
    step    = (state_q == ST_WRITE) & rdy_i;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_READ;
      ST_READ:  if (rdy_i)  state_d = ST_WRITE;
      ST_WRITE: if (rdy_i)  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    dir_ce  = accept;
    dir_d   = (src_id_i == RX_ID);
    data_ce = (state_q == ST_READ) & rdy_i;
    data_d  = word_i ? rdata_i : {{HI_W{1'b0}}, rdata_i[7:0]};
    irq_d   = step & last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      data_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (dir_ce)  dir_q  <= dir_d;
      if (data_ce) data_q <= data_d;
    end
  end

  assign from_io_o   = dir_q;
  assign step_o      = step;
  assign bus_req_o   = (state_q != ST_IDLE);
  assign bus_we_o    = (state_q == ST_WRITE);
  assign bus_addr_o  = (state_q == ST_WRITE) ? dst_addr_i : src_addr_i;
  assign bus_wdata_o = data_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/dma_io_channel.sv
module dma_io_channel
  import dma_io_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 3,
  parameter int RX_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_we_i,
  input  logic [ADDR_W-1:0] mar_wd_i,
  input  logic              io_we_i,
  input  logic [IO_W-1:0]   io_wd_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wd_i,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_wd_i,
  input  logic              req_i,
  input  logic [SRC_W-1:0]  req_src_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_word_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              end_irq_o
);

  logic [ADDR_W-1:0] mar_q, mar_next, src_a, dst_a;
  logic [IO_W-1:0]   io_q;
  logic [CNT_W-1:0]  cnt_q;
  ctl_t              ctl_q;
  logic              last, step, from_io;

  dma_io_regs #(.ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .mar_we_i   (mar_we_i),
    .mar_wd_i   (mar_wd_i),
    .io_we_i    (io_we_i),
    .io_wd_i    (io_wd_i),
    .cnt_we_i   (cnt_we_i),
    .cnt_wd_i   (cnt_wd_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_wd_i   (ctl_t'(ctl_wd_i)),
    .step_i     (step),
    .mar_next_i (mar_next),
    .mar_q_o    (mar_q),
    .io_q_o     (io_q),
    .cnt_q_o    (cnt_q),
    .ctl_q_o    (ctl_q),
    .last_o     (last)
  );

  dma_io_addr #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_addr (
    .mar_i      (mar_q),
    .io_i       (io_q),
    .word_i     (ctl_q.word),
    .dec_i      (ctl_q.dec),
    .from_io_i  (from_io),
    .mar_next_o (mar_next),
    .src_o      (src_a),
    .dst_o      (dst_a)
  );

  dma_io_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .RX_SRC(RX_SRC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ctl_q.en),
    .word_i      (ctl_q.word),
    .cnt_nz_i    (cnt_q != '0),
    .last_i      (last),
    .req_i       (req_i),
    .src_id_i    (req_src_i),
    .src_addr_i  (src_a),
    .dst_addr_i  (dst_a),
    .rdata_i     (bus_rdata_i),
    .rdy_i       (bus_rdy_i),
    .from_io_o   (from_io),
    .step_o      (step),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .irq_o       (end_irq_o)
  );

  assign bus_word_o = ctl_q.word;
  assign mar_o      = mar_q;
  assign cnt_o      = cnt_q;
  assign en_o       = ctl_q.en;

endmodule

// File: rtl/dma_io_channel_chk.sv
module dma_io_channel_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_word_o,
  input logic              bus_rdy_i,
  input logic              en_o,
  input logic              end_irq_o
);

  p_hold_until_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_rdy_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  p_read_then_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_we_o && bus_rdy_i) |=> (bus_req_o && bus_we_o));

  p_word_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_word_o) |-> !bus_addr_o[0]);

  p_irq_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq_o |=> !end_irq_o);

  p_irq_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq_o |-> !en_o);

  p_idle_when_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !bus_req_o) |=> !bus_req_o);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!bus_req_o && !end_irq_o && !en_o);
    end
  end

endmodule

bind dma_io_channel dma_io_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req_o  (bus_req_o),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_word_o (bus_word_o),
  .bus_rdy_i  (bus_rdy_i),
  .en_o       (en_o),
  .end_irq_o  (end_irq_o)
);

// File: tb/tb_dma_io_channel.sv
module tb_dma_io_channel;

  localparam int CLK_PERIOD = 10;
  localparam int RX = 2;

  typedef struct {
    bit          we;
    logic [23:0] addr;
    logic [15:0] data;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mar_we = 0, io_we = 0, cnt_we = 0, ctl_we = 0, req = 0;
  logic [23:0] mar_wd = '0;
  logic [7:0]  io_wd = '0;
  logic [15:0] cnt_wd = '0;
  logic [2:0]  ctl_wd = '0;
  logic [2:0]  src = '0;
  logic        bus_req, bus_we, bus_word, bus_rdy = 1'b0, en, irq;
  logic [23:0] bus_addr, mar;
  logic [15:0] bus_wdata, bus_rdata, cnt;

  int tests = 0, fails = 0, wait_cfg = 0, wcnt = 0, cyc = 0;
  item_t sb[$];

  // bench model
  logic [23:0] m_mar;
  logic [7:0]  m_io;
  logic [15:0] m_cnt;
  bit          m_en, m_word, m_dec;

  dma_io_channel dut (
    .clk(clk), .rst_n(rst_n),
    .mar_we_i(mar_we), .mar_wd_i(mar_wd), .io_we_i(io_we), .io_wd_i(io_wd),
    .cnt_we_i(cnt_we), .cnt_wd_i(cnt_wd), .ctl_we_i(ctl_we), .ctl_wd_i(ctl_wd),
    .req_i(req), .req_src_i(src),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_word_o(bus_word), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_rdy_i(bus_rdy), .mar_o(mar), .cnt_o(cnt), .en_o(en), .end_irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rd_val(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // slave + monitor: decide ready at negedge, compare completed cycles
  always @(negedge clk) begin
    cyc++;
    if (bus_req) begin
      if (wcnt >= wait_cfg) begin
        bus_rdy <= 1'b1;
        wcnt = 0;
        if (sb.size() == 0) begin
          chk(0, "R7 unexpected bus cycle", {8'h0, bus_addr}, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(bus_we == it.we && bus_addr == it.addr, it.tag, {7'h0, bus_we, bus_addr}, {7'h0, it.we, it.addr});
          if (it.we) chk(bus_wdata == it.data, "R1/R8 write data", bus_wdata, it.data);
        end
      end else begin
        bus_rdy <= 1'b0;
        wcnt++;
      end
    end else begin
      bus_rdy <= 1'b0;
      wcnt = 0;
    end
  end

  assign bus_rdata = rd_val(bus_addr);

  task automatic wr(input int k, input logic [23:0] v);
    @(negedge clk);
    case (k)
      0: begin mar_we = 1; mar_wd = v; m_mar = v; end
      1: begin io_we = 1; io_wd = v[7:0]; m_io = v[7:0]; end
      2: begin cnt_we = 1; cnt_wd = v[15:0]; m_cnt = v[15:0]; end
      default: begin ctl_we = 1; ctl_wd = v[2:0]; m_en = v[0]; m_word = v[1]; m_dec = v[2]; end
    endcase
    @(negedge clk);
    mar_we = 0; io_we = 0; cnt_we = 0; ctl_we = 0;
  endtask

  task automatic do_req(input logic [2:0] s, input bit extra);
    bit acc, last;
    logic [23:0] ma, ia, sa, da;
    logic [15:0] d;
    acc  = m_en && (m_cnt != 0);
    last = 0;
    if (acc) begin
      ma = m_mar; ia = {16'hFFFF, m_io};
      if (m_word) begin ma[0] = 0; ia[0] = 0; end
      sa = (s == RX) ? ia : ma;
      da = (s == RX) ? ma : ia;
      d  = m_word ? rd_val(sa) : {8'h00, rd_val(sa)[7:0]};
      sb.push_back('{0, sa, 16'h0, (s == RX) ? "R2 read from peripheral" : "R3 read from memory"});
      sb.push_back('{1, da, d, (s == RX) ? "R2 write to memory" : "R3/R4 write to peripheral"});
      m_mar = m_dec ? m_mar - (m_word ? 24'd2 : 24'd1) : m_mar + (m_word ? 24'd2 : 24'd1);
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin m_en = 0; last = 1; end
    end
    @(negedge clk);
    req = 1; src = s;
    @(negedge clk);
    req = extra;
    @(negedge clk);
    req = 0;
    while (bus_req) @(negedge clk);
    chk(irq == last, "R6 end pulse", irq, last);
    @(negedge clk);
    chk(irq == 0, "R6 pulse one clock", irq, 0);
    chk(mar == m_mar, "R5 pointer", mar, m_mar);
    chk(cnt == m_cnt, "R6 count", cnt, m_cnt);
    chk(en == m_en, "R6/R7 enable", en, m_en);
    chk(sb.size() == 0, "R1 all cycles seen", sb.size(), 0);
  endtask

  initial begin
    while (cyc < 50000) @(negedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_mar = 0; m_io = 0; m_cnt = 0; m_en = 0; m_word = 0; m_dec = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !irq && !en, "R10 reset state", {bus_req, irq, en}, 0);
    rst_n = 1;

    // byte, up, non-receive source, three transfers
    wr(0, 24'h001000); wr(1, 24'h40); wr(2, 3); wr(3, 3'b001);
    do_req(3'd1, 0); do_req(3'd0, 0); do_req(3'd5, 0);
    chk(mar == 24'h001003, "R5 byte up total", mar, 24'h001003);

    // disabled channel ignores a request
    do_req(3'd1, 0);
    chk(mar == 24'h001003, "R7 disabled no change", mar, 24'h001003);

    // word, down, receive source, odd pointer, odd low byte
    wr(0, 24'h002001); wr(1, 24'h81); wr(2, 2); wr(3, 3'b111);
    do_req(3'(RX), 0); do_req(3'(RX), 0);
    chk(mar == 24'h001FFD, "R5 word down total", mar, 24'h001FFD);

    // busy channel ignores a second request, slow bus
    wait_cfg = 3;
    wr(0, 24'h003000); wr(1, 24'h10); wr(2, 5); wr(3, 3'b001);
    do_req(3'd0, 1);
    chk(cnt == 16'd4, "R7 busy request dropped", cnt, 4);
    do_req(3'(RX), 0);

    // enabled with zero count ignores requests
    wait_cfg = 1;
    wr(2, 0); wr(3, 3'b011);
    do_req(3'd1, 0);
    chk(en == 1'b1 && cnt == 0, "R7 zero count", {en, cnt}, {1'b1, 16'h0});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule